// File: doc/BRIEF.md
# Systolic MAC Processing Grid

A four-element multiply-accumulate array, two rows by two columns, for small convolution kernels. Each element keeps a 2-bit signed weight, a 6-bit signed activation and a 13-bit running partial sum. On each move, activations step one element along a path. The path is chosen at run time: a horizontal snake, a vertical snake, or a closed ring that circulates the activations already loaded. Each element multiplies the activation it receives by its weight and adds the product to its partial sum.

Results leave through one 13-bit port. The port always shows the partial sum of the element at row 0, column 0. Shift cycles move every partial sum one place toward that element, so the sums can be read out one after another. Elements are indexed E0 = (row 0, col 0), E1 = (row 0, col 1), E2 = (row 1, col 0) and E3 = (row 1, col 1).

Top module: `systolic_mac_grid`

## Requirements
- R1: While `rst_n` is low, every activation, weight and partial sum is cleared to zero, so `psum_out` reads 0.
- R2: In a cycle with `en` and `load_w` high, E0 and E2 take `w_col0` and E1 and E3 take `w_col1`. Weights are 2-bit two's complement: 2'b01 = +1, 2'b11 = -1, 2'b10 = -2.
- R3: In a cycle with `en` and `act_step` high and neither `sum_clr` nor `sum_shift` high, each element adds to its partial sum the product of two values: its weight as it stood before that cycle, and the activation it holds after the step. Activations are 6-bit signed. The product is sign-extended to 13 bits and the sum wraps modulo 2^13.
- R4: `dir` = 2'b10 steps activations along E0→E1→E3→E2, with `h_act_in` entering E0.
- R5: `dir` = 2'b01 steps activations along E0→E2→E3→E1, with `v_act_in` entering E0.
- R6: `dir` = 2'b11 steps activations around the ring E0→E1→E3→E2→E0. Both boundary inputs are ignored.
- R7: `dir` = 2'b00 leaves every activation where it is, even when `act_step` is high. A MAC still takes place, using the held activations.
- R8: `sum_clr` with `en` zeroes all four partial sums. It overrides both a shift and a MAC in the same cycle.
- R9: `sum_shift` with `en` (and no clear) moves the sums as E1→E0, E3→E1, E2→E3, and loads zero into E2. `psum_out` always shows E0's sum. A shift replaces the MAC of that cycle, but activations still step if `act_step` is high.
- R10: With `en` low, no activation, weight or partial sum changes, whatever the other inputs do.
- R11: After a clear, loading +1 into both columns, stepping 5 then 7 in on the horizontal path and then four more steps of zero gives `psum_out` = 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Global enable; low freezes all state |
| act_step | input | 1 | Step activations along the selected path and accumulate |
| sum_shift | input | 1 | Shift partial sums toward the output element |
| sum_clr | input | 1 | Zero all partial sums |
| load_w | input | 1 | Capture the per-column weights |
| dir | input | 2 | Path select: 10 horizontal, 01 vertical, 11 ring, 00 hold |
| h_act_in | input | 6 | Activation entering on the horizontal path |
| v_act_in | input | 6 | Activation entering on the vertical path |
| w_col0 | input | 2 | Weight for column 0 |
| w_col1 | input | 2 | Weight for column 1 |
| psum_out | output | 13 | Partial sum of element E0 |

## Verification
Several pairs of operations can be requested in the same cycle: clear with shift, shift with an activation step, and weight load with an activation step. The bench drives each of these pairs on purpose. For a clear with a shift, all sums must be zero afterwards. For a shift with a step, the sums must move while the activations still advance. For a load with a step, the product must use the old weight. The outcome is judged by draining or further stepping through `psum_out`. A behavioural model compares that output on every clock, including a long random stream in which such collisions occur often.

// File: rtl/systolic_mac_grid.sv
module systolic_mac_grid #(
  parameter int ACT_W = 6,
  parameter int W_W   = 2,
  parameter int ACC_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             act_step,
  input  logic             sum_shift,
  input  logic             sum_clr,
  input  logic             load_w,
  input  logic [1:0]       dir,
  input  logic [ACT_W-1:0] h_act_in,
  input  logic [ACT_W-1:0] v_act_in,
  input  logic [W_W-1:0]   w_col0,
  input  logic [W_W-1:0]   w_col1,
  output logic [ACC_W-1:0] psum_out
);
  localparam int N      = 4;
  localparam int PROD_W = ACT_W + W_W;

  logic [N-1:0][ACT_W-1:0] act, act_nxt;
  logic [N-1:0][W_W-1:0]   wt;
  logic [N-1:0][ACC_W-1:0] acc, acc_up, term;

  function automatic logic [ACC_W-1:0] mac_term(input logic [ACT_W-1:0] a, input logic [W_W-1:0] w);
    logic signed [PROD_W-1:0] p;
    p = $signed(a) * $signed(w);
    return {{(ACC_W-PROD_W){p[PROD_W-1]}}, p};
  endfunction

  always_comb begin
    act_nxt = act;
    case (dir)
      2'b10: begin
        act_nxt[0] = h_act_in;
        act_nxt[1] = act[0];
        act_nxt[3] = act[1];
        act_nxt[2] = act[3];
      end
      2'b01: begin
        act_nxt[0] = v_act_in;
        act_nxt[2] = act[0];
        act_nxt[3] = act[2];
        act_nxt[1] = act[3];
      end
      2'b11: begin
        act_nxt[0] = act[2];
        act_nxt[1] = act[0];
        act_nxt[3] = act[1];
        act_nxt[2] = act[3];
      end
      default: ;
    endcase
  end

  always_comb begin
    for (int k = 0; k < N; k++) term[k] = mac_term(act_nxt[k], wt[k]);
  end

  assign acc_up[0] = acc[1];
  assign acc_up[1] = acc[3];
  assign acc_up[3] = acc[2];
  assign acc_up[2] = '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= '0;
      wt  <= '0;
      acc <= '0;
    end else if (en) begin
      if (act_step) act <= act_nxt;
      for (int k = 0; k < N; k++) begin
        if (load_w) wt[k] <= (k % 2 == 1) ? w_col1 : w_col0;
        if (sum_clr)        acc[k] <= '0;
        else if (sum_shift) acc[k] <= acc_up[k];
        else if (act_step)  acc[k] <= acc[k] + term[k];
      end
    end
  end

  assign psum_out = acc[0];
endmodule

// File: rtl/grid_checker.sv
module grid_checker #(
  parameter int ACT_W = 6,
  parameter int W_W   = 2,
  parameter int ACC_W = 13
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    en,
  input logic                    act_step,
  input logic                    sum_shift,
  input logic                    sum_clr,
  input logic                    load_w,
  input logic [1:0]              dir,
  input logic [W_W-1:0]          w_col0,
  input logic [W_W-1:0]          w_col1,
  input logic [ACC_W-1:0]        psum_out,
  input logic [3:0][ACT_W-1:0]   act,
  input logic [3:0][W_W-1:0]     wt,
  input logic [3:0][ACC_W-1:0]   acc
);
  a_r10_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(act) && $stable(wt) && $stable(acc));

  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    en && sum_clr |=> acc == '0 && psum_out == '0);

  a_r9_shift_out: assert property (@(posedge clk) disable iff (!rst_n)
    en && sum_shift && !sum_clr |=> psum_out == $past(acc[1]) && acc[2] == '0);

  a_r6_ring_turn: assert property (@(posedge clk) disable iff (!rst_n)
    en && act_step && dir == 2'b11 |=> act[0] == $past(act[2]) && act[1] == $past(act[0]));

  a_r7_hold_path: assert property (@(posedge clk) disable iff (!rst_n)
    en && act_step && dir == 2'b00 |=> $stable(act));

  a_r2_column_load: assert property (@(posedge clk) disable iff (!rst_n)
    en && load_w |=> wt[0] == $past(w_col0) && wt[2] == $past(w_col0)
                  && wt[1] == $past(w_col1) && wt[3] == $past(w_col1));
endmodule

bind systolic_mac_grid grid_checker #(.ACT_W(ACT_W), .W_W(W_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .act_step(act_step), .sum_shift(sum_shift),
  .sum_clr(sum_clr), .load_w(load_w), .dir(dir), .w_col0(w_col0), .w_col1(w_col1),
  .psum_out(psum_out), .act(act), .wt(wt), .acc(acc)
);

// File: tb/sim_systolic_mac_grid.sv
module sim_systolic_mac_grid;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        en = 0, act_step = 0, sum_shift = 0, sum_clr = 0, load_w = 0;
  logic [1:0]  dir = 0;
  logic [5:0]  h_act_in = 0, v_act_in = 0;
  logic [1:0]  w_col0 = 0, w_col1 = 0;
  logic [12:0] psum_out;

  int checks = 0, errors = 0;
  int m_act[4], m_wt[4];
  logic signed [12:0] m_acc[4];
  int hp[4] = '{0, 1, 3, 2};
  int vp[4] = '{0, 2, 3, 1};

  always #(CLK_PERIOD/2) clk = ~clk;

  systolic_mac_grid u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .act_step(act_step), .sum_shift(sum_shift),
    .sum_clr(sum_clr), .load_w(load_w), .dir(dir), .h_act_in(h_act_in),
    .v_act_in(v_act_in), .w_col0(w_col0), .w_col1(w_col1), .psum_out(psum_out)
  );

  task automatic check(input string tag, input logic [12:0] got, input logic [12:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, $signed(got), $signed(exp));
    end
  endtask

  task automatic model(input bit e, mv, sh, cl, wl, input int d, h, v, w0, w1);
    int nact[4];
    logic signed [12:0] old[4];
    if (!e) return;
    for (int k = 0; k < 4; k++) begin nact[k] = m_act[k]; old[k] = m_acc[k]; end
    if (d == 2 || d == 3) begin
      nact[hp[0]] = (d == 2) ? h : m_act[hp[3]];
      for (int i = 1; i < 4; i++) nact[hp[i]] = m_act[hp[i-1]];
    end else if (d == 1) begin
      nact[vp[0]] = v;
      for (int i = 1; i < 4; i++) nact[vp[i]] = m_act[vp[i-1]];
    end
    if (cl) for (int k = 0; k < 4; k++) m_acc[k] = 0;
    else if (sh) begin
      m_acc[0] = old[1]; m_acc[1] = old[3]; m_acc[3] = old[2]; m_acc[2] = 0;
    end else if (mv)
      for (int k = 0; k < 4; k++) m_acc[k] = old[k] + 13'(nact[k] * m_wt[k]);
    if (mv) for (int k = 0; k < 4; k++) m_act[k] = nact[k];
    if (wl) begin m_wt[0] = w0; m_wt[2] = w0; m_wt[1] = w1; m_wt[3] = w1; end
  endtask

  task automatic step(input bit e, mv, sh, cl, wl, input int d, h, v, w0, w1, input string tag);
    en = e; act_step = mv; sum_shift = sh; sum_clr = cl; load_w = wl;
    dir = 2'(d); h_act_in = 6'(h); v_act_in = 6'(v); w_col0 = 2'(w0); w_col1 = 2'(w1);
    @(posedge clk);
    model(e, mv, sh, cl, wl, d, h, v, w0, w1);
    @(negedge clk);
    check(tag, psum_out, m_acc[0]);
  endtask

  task automatic clear(input string tag); step(1, 0, 0, 1, 0, 0, 0, 0, 0, 0, tag); endtask
  task automatic load(input int w0, w1, input string tag); step(1, 0, 0, 0, 1, 0, 0, 0, w0, w1, tag); endtask
  task automatic move(input int d, h, v, input string tag); step(1, 1, 0, 0, 0, d, h, v, 0, 0, tag); endtask
  task automatic shift(input string tag); step(1, 0, 1, 0, 0, 0, 0, 0, 0, 0, tag); endtask
  task automatic drain(input string tag); for (int i = 0; i < 4; i++) shift(tag); endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) begin m_act[k] = 0; m_wt[k] = 0; m_acc[k] = 0; end
    repeat (2) @(negedge clk);
    check("R1 reset", psum_out, 13'd0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", psum_out, 13'd0);

    // R11 worked example on the horizontal path
    clear("R8");
    load(1, 1, "R2");
    move(2, 5, 0, "R4");
    move(2, 7, 0, "R4");
    for (int i = 0; i < 4; i++) move(2, 0, 0, "R4");
    check("R11 example", psum_out, 13'd12);
    drain("R9 drain");

    // R5 vertical path with negative and mixed weights
    clear("R8");
    load(-1, -2, "R2");
    move(1, 0, 9, "R5");
    move(1, 0, -13, "R5");
    move(1, 0, 31, "R5");
    move(1, 0, -32, "R5");
    move(2, 3, 0, "R4");
    drain("R9 vertical drain");

    // R6 ring with noisy boundaries, R7 hold
    clear("R8");
    load(1, -1, "R2");
    move(2, 4, 0, "R4");
    move(2, -6, 0, "R4");
    move(2, 11, 0, "R4");
    move(2, -1, 0, "R4");
    for (int i = 0; i < 6; i++) move(3, 17, -20, "R6 ring");
    move(0, 25, 25, "R7 hold");
    move(0, -9, 3, "R7 hold");
    drain("R6 drain");

    // R10 enable low with all strobes
    step(0, 1, 1, 1, 1, 2, 13, 13, 1, 1, "R10 frozen");
    step(0, 1, 0, 0, 1, 3, 0, 0, -2, -2, "R10 frozen");
    move(3, 0, 0, "R10 after freeze");

    // R8 clear together with shift
    step(1, 1, 1, 1, 0, 3, 0, 0, 0, 0, "R8 clear beats shift");
    drain("R8 all zero");
    // R9 shift together with a step
    move(2, 10, 0, "R4");
    step(1, 1, 1, 0, 0, 2, 20, 0, 0, 0, "R9 shift with step");
    move(3, 0, 0, "R9 step after shift");
    // R3 load together with a step uses the old weight
    step(1, 1, 0, 0, 1, 2, 8, 0, -2, -2, "R3 old weight");
    move(2, 8, 0, "R3 new weight");
    drain("R3 drain");

    // R3 wrap: -32 * -2 accumulated past 2^12
    clear("R8");
    load(-2, -2, "R2");
    for (int i = 0; i < 4; i++) move(2, -32, 0, "R3");
    for (int i = 0; i < 140; i++) move(3, 0, 0, "R3 wrap");
    drain("R3 wrap drain");

    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] | r[1], r[2], r[3] & r[4], r[5] & r[6] & r[7], r[8] & r[9],
           int'(r[11:10]), int'($signed(r[17:12])), int'($signed(r[23:18])),
           int'($signed(r[25:24])), int'($signed(r[27:26])), "R3 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule